// File: doc/BRIEF.md
# Bandwidth-Throttled Memory Target with Retry

This block is the memory side of a request/response link. It accepts read and write requests against a small word array. It limits the short-term data rate by going busy after each read or write for a number of cycles. That number is the transfer size in bytes times a per-byte cycle cost fixed at elaboration. A request that arrives during a busy window is refused. The target remembers that it owes the requester a retry, and it raises a one-cycle retry pulse as soon as the window closes. The requester is expected to resend on that pulse.

Accepted requests that ask for a reply are served against the array in the cycle they are accepted. Their replies wait in a small in-order queue until a fixed access latency has passed, and then they are offered on the response channel. A request marked as inhibited means that another agent supplies the data. Such a request is taken and discarded: it has no storage effect and produces no reply. When the reply queue is full, the target refuses every other request without arming a retry, so the requester simply tries again later.

Top module: `bwmem_target`

## Requirements
- R1: Commands are encoded as req_cmd 0 = read, 1 = write, 2 and 3 = other. When a read or write of req_size bytes is accepted in cycle T and req_size*BYTE_COST = D > 0, every non-inhibited request in cycles T+1 to T+D is refused (req_accept low). A request in cycle T+D+1 is accepted again.
- R2: When req_size*BYTE_COST is zero, an accepted read or write starts no busy window, so a request in the next cycle is accepted.
- R3: An accepted command of type 2 or 3 starts no busy window, whatever its size.
- R4: When a non-inhibited request is refused during a busy window, retry_pulse is high for exactly one cycle: the first cycle after the window ends. Otherwise it stays low.
- R5: Once a retry is owed, further non-inhibited requests are refused and add nothing. A window with several refusals gives exactly one retry pulse.
- R6: A request with req_inhibit high is accepted in every state. It does not change the array, produces no response, and arms no retry.
- R7: A request accepted in cycle T with req_need_rsp high yields rsp_valid in cycle T+ACCESS_LAT, provided earlier replies have left and rsp_ready allows it. A read returns the word most recently written at req_addr. Any other command returns zero data. rsp_cmd echoes the command.
- R8: An accepted request with req_need_rsp low produces no response.
- R9: The reply queue holds QDEPTH entries. With QDEPTH replies waiting, every non-inhibited request is refused and no retry is armed. Replies leave in acceptance order. A reply holds its value while rsp_ready is low.
- R10: After reset no retry is owed, retry_pulse and rsp_valid are low, and the first request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 2 | Command: 0 read, 1 write, 2/3 other |
| req_need_rsp | input | 1 | Request expects a reply |
| req_inhibit | input | 1 | Another agent supplies data; take and discard |
| req_addr | input | ADDR_W | Word address |
| req_size | input | SIZE_W | Transfer size in bytes |
| req_wdata | input | DATA_W | Write data |
| req_accept | output | 1 | Request taken this cycle (low with req_valid = refused) |
| retry_pulse | output | 1 | One-cycle invitation to resend a refused request |
| rsp_valid | output | 1 | Reply offered |
| rsp_ready | input | 1 | Requester takes the reply |
| rsp_cmd | output | 2 | Command of the reply |
| rsp_data | output | DATA_W | Reply data |

## Verification
The hardest case to reach is a refusal in the very last busy cycle. It lands at the same edge at which the window expires, and it must still produce the retry pulse. A second hard case is the reply queue filling up while requests keep arriving. This needs the response channel held back for several cycles. The directed part of the stimulus builds both: a long busy window with refused requests in every one of its cycles, and a burst of reply-bearing reads with rsp_ready held low. A long random phase with mixed sizes, inhibits and back-pressure then drives the other overlaps, and a behavioural model is compared against the outputs every cycle.

// File: rtl/bwmem_pkg.sv
package bwmem_pkg;
   typedef enum logic [1:0] {
      CMD_READ  = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_OTHA  = 2'd2,
      CMD_OTHB  = 2'd3
   } bw_cmd_e;

   function automatic logic cmd_moves_data(input logic [1:0] c);
      return (c == CMD_READ) || (c == CMD_WRITE);
   endfunction
endpackage

// File: rtl/bwmem_throttle.sv
module bwmem_throttle #(
   parameter int SIZE_W    = 4,
   parameter int BYTE_COST = 2,
   parameter int DUR_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SIZE_W-1:0] start_size,
   input  logic              refuse,
   output logic              busy,
   output logic              pend,
   output logic              retry_pulse
);
   generate
      if (BYTE_COST == 0) begin : g_free
         assign busy        = 1'b0;
         assign pend        = 1'b0;
         assign retry_pulse = 1'b0;
      end else begin : g_timed
         logic [DUR_W-1:0] cnt_q;
         logic [DUR_W-1:0] dur;
         logic             pend_q;
         logic             pulse_q;

         assign dur         = DUR_W'(start_size) * DUR_W'(BYTE_COST);
         assign busy        = (cnt_q != '0);
         assign pend        = pend_q;
         assign retry_pulse = pulse_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q   <= '0;
               pend_q  <= 1'b0;
               pulse_q <= 1'b0;
            end else begin
               pulse_q <= 1'b0;
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - DUR_W'(1);
                  if (cnt_q == DUR_W'(1)) begin
                     pulse_q <= pend_q | refuse;
                     pend_q  <= 1'b0;
                  end else if (refuse) begin
                     pend_q <= 1'b1;
                  end
               end else if (start && (dur != '0)) begin
                  cnt_q <= dur;
               end
            end
         end

         assert_busy_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (start && !busy && (dur != '0)) |=> busy);
         assert_zero_dur_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (start && !busy && (dur == '0)) |=> !busy);
         assert_retry_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
            retry_pulse |-> (!busy && $past(busy)));
         assert_retry_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
            retry_pulse |=> !retry_pulse);
         assert_pend_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (pend && busy) |=> ((pend && busy) || retry_pulse));
      end
   endgenerate
endmodule

// File: rtl/bwmem_store.sv
module bwmem_store #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/bwmem_rspq.sv
module bwmem_rspq #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 4,
   parameter int LAT    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_push,
   input  logic [1:0]        in_cmd,
   input  logic [DATA_W-1:0] in_data,
   output logic              full,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_cmd,
   output logic [DATA_W-1:0] out_data
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(LAT - 1);

   logic [DATA_W-1:0] data_q [DEPTH];
   logic [1:0]        cmd_q  [DEPTH];
   logic [CNT_W-1:0]  wait_q [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [PTR_W:0]    count;
   logic              pop;

   assign full      = (count == (PTR_W+1)'(DEPTH));
   assign out_valid = (count != '0) && (wait_q[rd_ptr] == '0);
   assign pop       = out_valid && out_ready;
   assign out_data  = data_q[rd_ptr];
   assign out_cmd   = cmd_q[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < DEPTH; i++) wait_q[i] <= '0;
      end else begin
         if (in_push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop)     rd_ptr <= rd_ptr + PTR_W'(1);
         if (in_push && !pop)      count <= count + (PTR_W+1)'(1);
         else if (!in_push && pop) count <= count - (PTR_W+1)'(1);
         for (int i = 0; i < DEPTH; i++) begin
            if (in_push && (wr_ptr == PTR_W'(i))) wait_q[i] <= LOAD;
            else if (wait_q[i] != '0)             wait_q[i] <= wait_q[i] - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (in_push) begin
         data_q[wr_ptr] <= in_data;
         cmd_q[wr_ptr]  <= in_cmd;
      end
   end

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_push |-> !full);
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_cmd)));
endmodule

// File: rtl/bwmem_target.sv
module bwmem_target #(
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 16,
   parameter int SIZE_W     = 4,
   parameter int BYTE_COST  = 2,
   parameter int ACCESS_LAT = 3,
   parameter int QDEPTH     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_cmd,
   input  logic              req_need_rsp,
   input  logic              req_inhibit,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_accept,
   output logic              retry_pulse,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [1:0]        rsp_cmd,
   output logic [DATA_W-1:0] rsp_data
);
   import bwmem_pkg::*;

   localparam int COST_W = (BYTE_COST > 0) ? $clog2(BYTE_COST + 1) : 1;
   localparam int DUR_W  = SIZE_W + COST_W;

   generate
      if (ACCESS_LAT < 1) begin : g_bad_lat
         $error("ACCESS_LAT must be at least 1");
      end
      if ((QDEPTH < 2) || ((QDEPTH & (QDEPTH - 1)) != 0)) begin : g_bad_depth
         $error("QDEPTH must be a power of two of at least 2");
      end
      if (BYTE_COST < 0) begin : g_bad_cost
         $error("BYTE_COST must not be negative");
      end
   endgenerate

   logic              busy, pend, q_full;
   logic              plain, take, refuse_busy, start, mem_we, q_push;
   logic [DATA_W-1:0] rd_word, push_data;

   assign plain       = req_valid && !req_inhibit;
   assign take        = plain && !busy && !pend && !q_full;
   assign req_accept  = (req_valid && req_inhibit) || take;
   assign refuse_busy = plain && busy && !pend;
   assign start       = take && cmd_moves_data(req_cmd);
   assign mem_we      = take && (req_cmd == CMD_WRITE);
   assign q_push      = take && req_need_rsp;
   assign push_data   = (req_cmd == CMD_READ) ? rd_word : '0;

   bwmem_throttle #(
      .SIZE_W(SIZE_W), .BYTE_COST(BYTE_COST), .DUR_W(DUR_W)
   ) u_throttle (
      .clk(clk), .rst_n(rst_n), .start(start), .start_size(req_size),
      .refuse(refuse_busy), .busy(busy), .pend(pend), .retry_pulse(retry_pulse)
   );

   bwmem_store #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_store (
      .clk(clk), .we(mem_we), .addr(req_addr), .wdata(req_wdata), .rdata(rd_word)
   );

   bwmem_rspq #(
      .DATA_W(DATA_W), .DEPTH(QDEPTH), .LAT(ACCESS_LAT)
   ) u_rspq (
      .clk(clk), .rst_n(rst_n), .in_push(q_push), .in_cmd(req_cmd),
      .in_data(push_data), .full(q_full), .out_valid(rsp_valid),
      .out_ready(rsp_ready), .out_cmd(rsp_cmd), .out_data(rsp_data)
   );

   assert_busy_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid && !req_inhibit) |-> !req_accept);
   assert_other_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_accept && plain && !cmd_moves_data(req_cmd) && !busy) |=> !busy);
   assert_pend_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && plain) |-> !req_accept);
   assert_inhibit_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_inhibit) |-> req_accept);
endmodule

// File: tb/bwmem_target_tb.sv
`timescale 1ns/1ps
module bwmem_target_tb;
   localparam int COST = 2;
   localparam int LAT  = 3;
   localparam int QD   = 4;
   localparam int LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_need_rsp = 1'b0, req_inhibit = 1'b0, rsp_ready = 1'b1;
   logic [1:0]  req_cmd = 2'd0;
   logic [3:0]  req_addr = '0, req_size = '0;
   logic [15:0] req_wdata = '0;
   logic        req_accept, retry_pulse, rsp_valid;
   logic [1:0]  rsp_cmd;
   logic [15:0] rsp_data;

   int total = 0, bad = 0, cycles = 0;
   bit done = 0;
   logic nxt_ready = 1'b1;

   always #2 clk = ~clk;

   bwmem_target u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
      .req_need_rsp(req_need_rsp), .req_inhibit(req_inhibit), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata), .req_accept(req_accept),
      .retry_pulse(retry_pulse), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_cmd(rsp_cmd), .rsp_data(rsp_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // ---------------- behavioural reference ----------------
   typedef struct { int rel; logic [15:0] data; logic [1:0] cmd; } rsp_t;
   rsp_t        m_q[$];
   int          m_cnt = 0, now = 0;
   bit          m_pend = 0, m_retry = 0;
   logic [15:0] m_mem [16];

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_cnt = 0; m_pend = 0; m_retry = 0; now = 0; m_q.delete();
      end else begin
         bit plain, take, refb, pop;
         logic [15:0] rd;
         rsp_t e;
         plain = req_valid && !req_inhibit;
         take  = plain && m_cnt == 0 && !m_pend && m_q.size() < QD;
         refb  = plain && m_cnt != 0 && !m_pend;
         pop   = m_q.size() > 0 && m_q[0].rel <= now && rsp_ready;
         m_retry = 0;
         if (m_cnt != 0) begin
            m_cnt--;
            if (m_cnt == 0) begin m_retry = m_pend || refb; m_pend = 0; end
            else if (refb) m_pend = 1;
         end else if (take && req_cmd <= 2'd1) begin
            m_cnt = int'(req_size) * COST;
         end
         rd = m_mem[req_addr];
         if (take && req_cmd == 2'd1) m_mem[req_addr] = req_wdata;
         if (pop) void'(m_q.pop_front());
         if (take && req_need_rsp) begin
            e.rel = now + LAT; e.cmd = req_cmd;
            e.data = (req_cmd == 2'd0) ? rd : 16'h0;
            m_q.push_back(e);
         end
         now++;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit ea, ev;
         ea = req_valid && (req_inhibit || (m_cnt == 0 && !m_pend && m_q.size() < QD));
         ev = m_q.size() > 0 && m_q[0].rel <= now;
         chk("R1 accept", 32'(req_accept), 32'(ea));
         chk("R4 retry", 32'(retry_pulse), 32'(m_retry));
         chk("R7 rsp_valid", 32'(rsp_valid), 32'(ev));
         if (ev) begin
            chk("R7 rsp_data", 32'(rsp_data), 32'(m_q[0].data));
            chk("R7 rsp_cmd", 32'(rsp_cmd), 32'(m_q[0].cmd));
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic cyc(input logic v, input logic [1:0] c, input logic nr, input logic inh,
                      input logic [3:0] a, input logic [3:0] s, input logic [15:0] d);
      @(posedge clk);
      #1;
      req_valid = v; req_cmd = c; req_need_rsp = nr; req_inhibit = inh;
      req_addr = a; req_size = s; req_wdata = d; rsp_ready = nxt_ready;
      @(negedge clk);
   endtask

   task automatic idle();
      cyc(1'b0, 2'd0, 1'b0, 1'b0, 4'd0, 4'd0, 16'h0);
   endtask

   always @(posedge clk) begin
      if (cycles > LIMIT && !done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R10: reset state
      @(negedge clk);
      chk("R10 retry after reset", 32'(retry_pulse), 32'd0);
      chk("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);

      // R2 / R8 / R10: fill array with size-0 writes, each accepted back to back
      for (int i = 0; i < 16; i++) begin
         cyc(1'b1, 2'd1, 1'b0, 1'b0, 4'(i), 4'd0, 16'hA000 | 16'(i));
         chk(i == 0 ? "R10 first accept" : "R2 zero-size accept", 32'(req_accept), 32'd1);
         chk("R8 no response", 32'(rsp_valid), 32'd0);
      end
      idle();

      // R1 / R4 / R5 / R7: read of 3 bytes -> 6 busy cycles
      cyc(1'b1, 2'd0, 1'b1, 1'b0, 4'd3, 4'd3, 16'h0);
      chk("R1 start accept", 32'(req_accept), 32'd1);
      for (int k = 1; k <= 6; k++) begin
         cyc(1'b1, 2'd1, 1'b0, 1'b0, 4'd9, 4'd1, 16'hBEEF);
         chk("R1 refused while busy", 32'(req_accept), 32'd0);
         chk("R5 no early retry", 32'(retry_pulse), 32'd0);
         if (k == LAT) begin
            chk("R7 response due", 32'(rsp_valid), 32'd1);
            chk("R7 read data", 32'(rsp_data), 32'hA003);
         end
      end
      idle();
      chk("R4 retry pulse", 32'(retry_pulse), 32'd1);
      idle();
      chk("R4 single pulse", 32'(retry_pulse), 32'd0);

      // R3: other command with large size does not throttle
      cyc(1'b1, 2'd2, 1'b1, 1'b0, 4'd0, 4'd7, 16'h0);
      chk("R3 other accepted", 32'(req_accept), 32'd1);
      cyc(1'b1, 2'd0, 1'b1, 1'b0, 4'd1, 4'd0, 16'h0);
      chk("R3 next accepted", 32'(req_accept), 32'd1);
      repeat (4) idle();

      // R6: inhibited write during busy window
      cyc(1'b1, 2'd0, 1'b0, 1'b0, 4'd0, 4'd2, 16'h0);
      cyc(1'b1, 2'd1, 1'b1, 1'b1, 4'd5, 4'd1, 16'h5555);
      chk("R6 inhibit accepted while busy", 32'(req_accept), 32'd1);
      cyc(1'b1, 2'd1, 1'b0, 1'b0, 4'd6, 4'd1, 16'h6666);
      chk("R6 normal refused", 32'(req_accept), 32'd0);
      repeat (4) idle();
      cyc(1'b1, 2'd0, 1'b1, 1'b0, 4'd5, 4'd0, 16'h0);
      chk("R6 read accepted", 32'(req_accept), 32'd1);
      idle(); idle(); idle();
      chk("R6 read response", 32'(rsp_valid), 32'd1);
      chk("R6 array untouched", 32'(rsp_data), 32'hA005);
      idle();

      // R9: queue full with rsp_ready low
      nxt_ready = 1'b0;
      for (int i = 0; i < QD; i++) begin
         cyc(1'b1, 2'd0, 1'b1, 1'b0, 4'(i), 4'd0, 16'h0);
         chk("R9 fill accept", 32'(req_accept), 32'd1);
      end
      cyc(1'b1, 2'd0, 1'b1, 1'b0, 4'd7, 4'd0, 16'h0);
      chk("R9 refused when full", 32'(req_accept), 32'd0);
      repeat (3) idle();
      chk("R9 no retry from full", 32'(retry_pulse), 32'd0);
      chk("R9 held valid", 32'(rsp_valid), 32'd1);
      chk("R9 held data", 32'(rsp_data), 32'hA000);
      nxt_ready = 1'b1;
      for (int i = 0; i < QD; i++) begin
         idle();
         chk("R9 in-order drain", 32'(rsp_data), 32'hA000 | 32'(i));
      end
      idle();

      // random phase, compared every clock by the reference
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] sz;
         sz = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'($urandom % 3);
         nxt_ready = ($urandom % 4) != 0;
         cyc(($urandom % 4) != 0, 2'($urandom % 4), 1'($urandom % 2),
             ($urandom % 10) == 0, 4'($urandom % 16), sz, 16'($urandom));
      end
      nxt_ready = 1'b1;
      repeat (40) idle();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule